// File: doc/BRIEF.md
# Host Command and Completion Queue Register Port

This block is the device-side register port of a storage host adapter. The host hands commands over by writing each command's bus address into a request queue. It collects finished work by reading completion tags out of a reply queue. All of this traffic uses 32-bit register reads and writes on a simple strobe bus. The block also holds an interrupt mask with inverted polarity, an interrupt status word, a general doorbell word and a scratchpad that tells the host when the device has come up.

A small back-end stub stands in for the device engine. It takes at most one request per service period, turns the address into a completion tag and places that tag in the reply queue. The tag's error flag is set when the address matches a configurable pattern. A build-time parameter moves the mask and pending bit from bit 3 to bit 2.

Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `hostq_regs`

## Requirements
- R1: A write at offset 0x40 places `bus_wdata` in the request queue. The back end returns completion tags in the same order as the requests, with none lost or duplicated.
- R2: A read at offset 0x44 removes and returns the oldest completion tag. When the reply queue is empty the read returns 0xFFFFFFFF and removes nothing. The data appears one cycle after the read strobe.
- R3: A write at 0x40 while the request queue holds DEPTH entries is discarded. It also sets a sticky overflow flag, which reads as bit 0 of the status word at 0x30 and clears only on reset.
- R4: The mask word at 0x34 reads back the disable value after reset: 0x08, or 0x04 when ALT_BITS=1. Writing 0 enables the reply interrupt. Only the mask bit (bit 3, or bit 2 when ALT_BITS=1) is stored.
- R5: In the status word at 0x30, bit 3 (bit 2 when ALT_BITS=1) reads 1 exactly while the reply queue is not empty, whatever the mask holds.
- R6: `irq` is high exactly while the pending bit is 1 and the stored mask bit is 0.
- R7: The scratchpad at 0xB0 reads 0 for the first READY_DELAY cycles after reset. After that it reads 0xFFFF0000 and stays there.
- R8: A completion tag equals its request address with bit 1 replaced by the error flag. The error flag is 1 when (address & ERR_MASK) == ERR_MATCH, and 0 otherwise.
- R9: The back end moves at most one entry per SERVICE_PERIOD cycles. It stalls without loss while the reply queue is full.
- R10: The doorbell word at 0x20 stores the full 32-bit value written to it and reads it back.
- R11: Reads at unmapped offsets return 0. Writes to the status word and the scratchpad change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Reply interrupt, pending and unmasked |

## Verification
The bench reads the reply port on an empty queue. A design that popped anyway or returned stale data would break the all-ones result or lose the next tag. It fills the reply queue first so that the back end stalls, then fills the request queue and pushes once more. A design that dropped or duplicated entries at the full boundary, or forgot the overflow flag, would show up in the order check on the drained tags. A second instance built with the alternate bit position takes the same mask writes. Because each instance reacts to a different mask bit, a polarity or bit-position mistake makes the two `irq` outputs disagree. Random address bursts with error-pattern hits check the bit-1 rewrite of the tags, including addresses that already have bit 1 set.

// File: rtl/hostq_pkg.sv
// Shared constants and helpers for the host queue register port.
// Assumes byte offsets are 8 bits wide and all accesses are full 32-bit words.
package hostq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_BELL = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_REQ  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RSP  = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_SCR  = 8'hB0;

    localparam logic [DATA_W-1:0] WORD_EMPTY = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] WORD_READY = 32'hFFFF_0000;

    // Build a completion tag: the address with bit 1 carrying the error flag.
    function automatic logic [DATA_W-1:0] make_tag(input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] m,
                                                   input logic [DATA_W-1:0] x);
        return {a[DATA_W-1:2], ((a & m) == x), a[0]};
    endfunction
endpackage

// File: rtl/hostq_fifo.sv
// Synchronous FIFO with an occupancy count.
// A push while full and a pop while empty are ignored. A push and a pop
// in the same cycle are both honoured. The head is shown without a pop.
module hostq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Store an accepted entry.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/hostq_backend.sv
// Back-end stub: moves one request to the reply queue per service period.
// The period counter runs only while a request is waiting. It holds at the
// last step while the reply queue is full, so the move happens on the first
// cycle that has room.
module hostq_backend
    import hostq_pkg::*;
#(
    parameter int          PERIOD    = 4,
    parameter logic [31:0] ERR_MASK  = 32'h0000_001C,
    parameter logic [31:0] ERR_MATCH = 32'h0000_0018,
    localparam int         PW        = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_empty,
    input  logic [DATA_W-1:0] req_head,
    input  logic              rsp_full,
    output logic              xfer,
    output logic [DATA_W-1:0] tag
);
    logic [PW-1:0] step;
    logic          at_end;

    assign at_end = (step == PW'(PERIOD - 1));
    assign xfer   = !req_empty && at_end && !rsp_full;
    assign tag    = make_tag(req_head, ERR_MASK, ERR_MATCH);

    // Count service cycles while work is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || req_empty) begin
            step <= '0;
        end else if (at_end) begin
            if (!rsp_full) step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end
endmodule

// File: rtl/hostq_ready.sv
// Start-up timer: raises ready after DELAY clock cycles out of reset and
// keeps it high until the next reset.
module hostq_ready #(
    parameter int  DELAY = 64,
    localparam int RW    = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    logic [RW-1:0] ticks;

    // Count up to the delay, then latch ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            ticks <= ticks + 1'b1;
            if (ticks == RW'(DELAY - 1)) ready <= 1'b1;
        end
    end
endmodule

// File: rtl/hostq_regs.sv
// Register port for the host command and completion queues.
// It decodes the offsets, applies the push and pop side effects, keeps the
// inverted-polarity mask and the sticky overflow flag, and drives the
// interrupt. The host is assumed to issue one single-cycle access at a time
// and never to assert bus_wr and bus_rd together.
module hostq_regs
    import hostq_pkg::*;
#(
    parameter int          DEPTH          = 8,
    parameter int          SERVICE_PERIOD = 4,
    parameter int          READY_DELAY    = 64,
    parameter bit          ALT_BITS       = 1'b0,
    parameter logic [31:0] ERR_MASK       = 32'h0000_001C,
    parameter logic [31:0] ERR_MATCH      = 32'h0000_0018,
    localparam int         FLAG_BIT       = ALT_BITS ? 2 : 3,
    localparam int         CW             = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              req_hit, rsp_hit;
    logic              req_full, req_empty, rsp_full, rsp_empty;
    logic [CW-1:0]     req_cnt, rsp_cnt;
    logic [DATA_W-1:0] req_head, rsp_head, bk_tag;
    logic              xfer, rsp_pop;
    logic              mask_q, ovf_q, ready_q;
    logic [DATA_W-1:0] bell_q, rd_mux;

    assign req_hit = bus_wr && (bus_addr == OFS_REQ);
    assign rsp_hit = bus_rd && (bus_addr == OFS_RSP);
    assign rsp_pop = rsp_hit && !rsp_empty;
    assign irq     = !rsp_empty && !mask_q;

    hostq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_req_q (
        .clk(clk), .rst_n(rst_n), .push(req_hit), .pop(xfer),
        .wdata(bus_wdata), .head(req_head), .count(req_cnt),
        .full(req_full), .empty(req_empty)
    );

    hostq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rsp_q (
        .clk(clk), .rst_n(rst_n), .push(xfer), .pop(rsp_pop),
        .wdata(bk_tag), .head(rsp_head), .count(rsp_cnt),
        .full(rsp_full), .empty(rsp_empty)
    );

    hostq_backend #(.PERIOD(SERVICE_PERIOD), .ERR_MASK(ERR_MASK), .ERR_MATCH(ERR_MATCH)) u_engine (
        .clk(clk), .rst_n(rst_n), .req_empty(req_empty), .req_head(req_head),
        .rsp_full(rsp_full), .xfer(xfer), .tag(bk_tag)
    );

    hostq_ready #(.DELAY(READY_DELAY)) u_boot (
        .clk(clk), .rst_n(rst_n), .ready(ready_q)
    );

    // Writable words: mask bit, doorbell, sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            bell_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == OFS_MASK) mask_q <= bus_wdata[FLAG_BIT];
            if (bus_wr && bus_addr == OFS_BELL) bell_q <= bus_wdata;
            if (req_hit && req_full)            ovf_q  <= 1'b1;
        end
    end

    // Select the read value for the addressed word.
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_STAT: begin
                rd_mux[FLAG_BIT] = !rsp_empty;
                rd_mux[0]        = ovf_q;
            end
            OFS_MASK: rd_mux[FLAG_BIT] = mask_q;
            OFS_BELL: rd_mux = bell_q;
            OFS_RSP:  rd_mux = rsp_empty ? WORD_EMPTY : rsp_head;
            OFS_SCR:  rd_mux = ready_q ? WORD_READY : '0;
            default:  rd_mux = '0;
        endcase
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/hostq_regs_chk.sv
// Assertion checker for hostq_regs, attached to every instance by bind.
// It watches the bus, the interrupt and the queue and flag state.
module hostq_regs_chk
    import hostq_pkg::*;
#(
    parameter int  DEPTH  = 8,
    parameter int  PERIOD = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              mask_q,
    input logic              ovf_q,
    input logic              ready_q,
    input logic              xfer,
    input logic [CW-1:0]     req_cnt,
    input logic [CW-1:0]     rsp_cnt
);
    // R3: the request queue never holds more than DEPTH entries.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_cnt <= CW'(DEPTH));

    // R3: once set, the overflow flag stays set.
    p_sticky_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R2: an empty reply read returns all ones.
    p_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_RSP && rsp_cnt == '0 && !xfer) |=> bus_rdata == WORD_EMPTY);

    // R2: a reply read on a non-empty queue removes exactly one entry.
    p_pop_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_RSP && rsp_cnt != '0 && !xfer) |=> rsp_cnt == $past(rsp_cnt) - 1'b1);

    // R6: the interrupt implies unmasked, queued replies.
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!mask_q && rsp_cnt != '0));

    // R7: ready never falls back.
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> ready_q);

    // R7: the scratchpad reads 0 before ready.
    p_scratch_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_SCR && !ready_q) |=> bus_rdata == '0);

    // R9: back-end moves are spaced by the service period.
    if (PERIOD > 1) begin : g_spacing
        p_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
            xfer |=> !xfer);
    end
endmodule

bind hostq_regs hostq_regs_chk #(.DEPTH(DEPTH), .PERIOD(SERVICE_PERIOD)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .irq(irq), .mask_q(mask_q), .ovf_q(ovf_q),
    .ready_q(ready_q), .xfer(xfer), .req_cnt(req_cnt), .rsp_cnt(rsp_cnt)
);

// File: tb/test_hostq_regs.sv
// Self-checking bench for hostq_regs: directed corner cases plus seeded
// random request bursts. A second instance built with the alternate bit
// position shares the bus.
module test_hostq_regs;
    import hostq_pkg::*;

    localparam int          DEPTH  = 8;
    localparam int          PERIOD = 4;
    localparam logic [31:0] EMASK  = 32'h0000_001C;
    localparam logic [31:0] EMATCH = 32'h0000_0018;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_alt;
    logic        irq, irq_alt;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] rd_v, rd_alt_v;

    always #4 clk = ~clk;

    hostq_regs #(.DEPTH(DEPTH), .SERVICE_PERIOD(PERIOD), .READY_DELAY(64), .ALT_BITS(1'b0),
                 .ERR_MASK(EMASK), .ERR_MATCH(EMATCH)) i_hostq_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq(irq));

    hostq_regs #(.DEPTH(DEPTH), .SERVICE_PERIOD(PERIOD), .READY_DELAY(64), .ALT_BITS(1'b1),
                 .ERR_MASK(EMASK), .ERR_MATCH(EMATCH)) i_hostq_regs_alt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_alt), .irq(irq_alt));

    function automatic logic [31:0] exp_tag(input logic [31:0] a);
        logic err;
        err = ((a & EMASK) == EMATCH);
        return {a[31:2], err, a[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        rd_v = rdata;
        rd_alt_v = rdata_alt;
    endtask

    task automatic push_req(input logic [31:0] a, input bit expect_kept);
        bus_write(OFS_REQ, a);
        if (expect_kept) exp_q.push_back(exp_tag(a));
    endtask

    // Poll status and pop until every expected tag has been read, in order.
    task automatic drain(input string req);
        int guard = 0;
        while (exp_q.size() > 0 && guard < 2000) begin
            guard++;
            bus_read(OFS_STAT);
            if (rd_v[3]) begin
                bus_read(OFS_RSP);
                check(req, rd_v, exp_q.pop_front());
            end
        end
        if (exp_q.size() > 0) begin
            check(req, 32'(exp_q.size()), 32'd0);
            exp_q.delete();
        end
        bus_read(OFS_RSP);
        check("R2 empty read after drain", rd_v, WORD_EMPTY);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        check("R6 irq after reset", 32'(irq), 32'd0);
        bus_read(OFS_MASK);
        check("R4 mask reset", rd_v, 32'h08);
        check("R4 alt mask reset", rd_alt_v, 32'h04);
        bus_read(OFS_SCR);
        check("R7 scratchpad before ready", rd_v, 32'h0);
        bus_read(OFS_STAT);
        check("R5 status reset", rd_v, 32'h0);
        bus_read(OFS_RSP);
        check("R2 empty reply read", rd_v, WORD_EMPTY);
        bus_read(8'h10);
        check("R11 unmapped read", rd_v, 32'h0);

        // Doorbell and read-only words
        bus_write(OFS_BELL, 32'hA5A5_1234);
        bus_read(OFS_BELL);
        check("R10 doorbell readback", rd_v, 32'hA5A5_1234);
        bus_write(OFS_STAT, 32'hFFFF_FFFF);
        bus_write(OFS_SCR, 32'h0000_1234);
        bus_read(OFS_STAT);
        check("R11 status write ignored", rd_v, 32'h0);
        bus_read(OFS_SCR);
        check("R11 scratchpad write ignored", rd_v, 32'h0);

        // Interrupt gating and polarity in both variants
        bus_write(OFS_REQ, 32'h1000_0040);
        repeat (20) @(negedge clk);
        check("R6 masked irq", 32'(irq), 32'd0);
        bus_read(OFS_STAT);
        check("R5 pending while masked", rd_v, 32'h08);
        check("R5 alt pending bit", rd_alt_v, 32'h04);
        bus_write(OFS_MASK, 32'h0);
        bus_read(OFS_MASK);
        check("R4 mask enabled", rd_v, 32'h0);
        check("R6 irq enabled", 32'(irq), 32'd1);
        check("R6 alt irq enabled", 32'(irq_alt), 32'd1);
        bus_write(OFS_MASK, 32'h08);
        check("R6 irq masked by bit 3", 32'(irq), 32'd0);
        check("R6 alt irq ignores bit 3", 32'(irq_alt), 32'd1);
        bus_write(OFS_MASK, 32'h04);
        check("R6 irq ignores bit 2", 32'(irq), 32'd1);
        check("R6 alt irq masked by bit 2", 32'(irq_alt), 32'd0);
        bus_write(OFS_MASK, 32'h0);
        bus_read(OFS_RSP);
        check("R1 first tag", rd_v, 32'h1000_0040);
        check("R6 irq drops after pop", 32'(irq), 32'd0);
        bus_read(OFS_STAT);
        check("R5 pending clear", rd_v, 32'h0);
        bus_read(OFS_RSP);
        check("R2 empty read removes nothing", rd_v, WORD_EMPTY);

        // Error flag in tags
        push_req(32'h2000_0018, 1'b1);
        push_req(32'h2000_001B, 1'b1);
        push_req(32'h2000_0014, 1'b1);
        push_req(32'h2000_0016, 1'b1);
        check("R8 tag model error case", exp_tag(32'h2000_0019), 32'h2000_001B);
        drain("R8 error flag tags");

        // Scratchpad after start-up
        repeat (80) @(negedge clk);
        bus_read(OFS_SCR);
        check("R7 scratchpad ready", rd_v, WORD_READY);

        // Random bursts that never exceed the queue depth
        for (int round = 0; round < 20; round++) begin
            int n;
            n = 1 + int'($urandom % DEPTH);
            for (int k = 0; k < n; k++) push_req($urandom, 1'b1);
            drain("R1 random burst order");
        end

        // Overflow: stall the back end, fill requests, push once more
        bus_read(OFS_STAT);
        check("R3 no overflow yet", rd_v & 32'h1, 32'h0);
        for (int k = 0; k < DEPTH; k++) push_req(32'h3000_0000 + 32'(k * 32), 1'b1);
        repeat (DEPTH * PERIOD + 20) @(negedge clk);
        for (int k = 0; k < DEPTH; k++) push_req(32'h4000_0000 + 32'(k * 32), 1'b1);
        repeat (2 * PERIOD) @(negedge clk);
        push_req(32'h5555_5540, 1'b0);
        bus_read(OFS_STAT);
        check("R3 overflow flag set", rd_v, 32'h09);
        drain("R9 stalled back end keeps order");
        bus_read(OFS_STAT);
        check("R3 overflow flag sticky", rd_v, 32'h01);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule